// File: doc/BRIEF.md
# Matrix Key Scan Controller

The block walks a single high level across up to six drive lines of a key matrix and reads five sense lines while each drive line is active. A key that is down connects its drive line to its sense line, so the sense bit reads 1 only while that drive line is high. An open key reads 0. After every complete pass over the active drive lines the block builds a key image. It copies that image into a held key map only when two passes in a row give the same result and that result differs from the held map. In the cycle the map changes, a one-cycle ready pulse goes out.

A two-bit key-count select sets how many drive lines take part in the scan. The two lowest drive lines share their pins with segment outputs, and a line that is not scanned gives its pin back to segment use. A per-line flag tells the pin multiplexer outside the block which use each pin has. Each drive slot lasts a fixed number of scan ticks. The sense lines are read on the last tick of the slot, so they have half a slot or more to settle after the drive line switches.

Top module: `key_matrix_scan`

## Requirements
- R1: After reset, key_map_o is all zeros and ready_o is low.
- R2: pin_scan_o bit i is 1 when drive line i is scanned. Select 00 gives 6'b111111 (30 keys), 01 gives 6'b111110 (25 keys), and 10 or 11 give 6'b111100 (20 keys). The low select bit is ignored when the high bit is set.
- R3: At most one bit of drive_o is high at any time, and only on a line whose pin_scan_o bit is 1.
- R4: Drive lines are visited in ascending order from the lowest scanned line up to line 5, then the scan wraps back. Each line stays high for SLOT_TICKS scan ticks.
- R5: The scan advances only on clock cycles where tick_i is high. With tick_i low, drive_o holds.
- R6: sense_i is sampled only on the last tick of a slot. Values present during the first half of a slot have no effect.
- R7: Key bit line*5+s of key_map_o is 1 when sense_i[s] is high while drive line `line` is driven.
- R8: Key bits of lines that are not scanned read 0 in every newly latched map.
- R9: key_map_o changes only at the end of a complete pass, and only when that pass and the one before it gave the same image. A single deviating pass leaves the map unchanged.
- R10: ready_o is high for exactly one clock, in the cycle key_map_o takes a new value that differs from the old one. An identical result raises no pulse.
- R11: A change of the effective key-count select restarts the scan at the lowest scanned line on the next clock and discards the pass in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Scan tick enable, one slot step per high cycle |
| key_sel_i | input | 2 | Key-count select: 00 gives 30 keys, 01 gives 25, 1x gives 20 |
| sense_i | input | 5 | Matrix sense lines, 1 = key closed on the driven line |
| drive_o | output | 6 | Matrix drive lines, one high at a time |
| pin_scan_o | output | 6 | Per line: 1 = pin in key-scan use, 0 = segment use |
| key_map_o | output | 30 | Held key image, bit line*5+sense |
| ready_o | output | 1 | One-cycle pulse when key_map_o changes |

## Verification
The bench models the matrix itself. Each sense line is the OR of the pressed keys on the driven line. While a drive line is less than half a slot old, the model forces all sense lines high. Any sampling earlier than the last tick of the slot therefore corrupts the image.

A single key is swept through all thirty positions in every select value, which separates the index mapping, the release of lines that are not scanned, and whether a ready pulse should occur. Dense and alternating patterns follow. A key pressed for exactly one pass shows whether the two-pass agreement filter works. Captured drive sequences after forced restarts check the line order and the slot length, and a tick pause shows that the scan freezes.

// File: rtl/key_scan_pkg.sv
package key_scan_pkg;
  localparam int DRV_LINES = 6;
  localparam int SNS_LINES = 5;
  localparam int KEY_BITS  = DRV_LINES * SNS_LINES;
  localparam int LINE_W    = $clog2(DRV_LINES);

  typedef enum logic [1:0] {
    SPAN_FULL  = 2'd0,
    SPAN_LESS1 = 2'd1,
    SPAN_LESS2 = 2'd2
  } span_e;

  function automatic span_e span_decode(input logic [1:0] sel);
    if (sel[1]) return SPAN_LESS2;
    if (sel[0]) return SPAN_LESS1;
    return SPAN_FULL;
  endfunction

  function automatic logic [LINE_W-1:0] span_first(input span_e s);
    case (s)
      SPAN_LESS1: return LINE_W'(1);
      SPAN_LESS2: return LINE_W'(2);
      default:    return LINE_W'(0);
    endcase
  endfunction

  function automatic logic [DRV_LINES-1:0] span_lines(input span_e s);
    logic [DRV_LINES-1:0] m;
    for (int i = 0; i < DRV_LINES; i++) m[i] = (LINE_W'(i) >= span_first(s));
    return m;
  endfunction

  function automatic logic [KEY_BITS-1:0] span_keys(input span_e s);
    logic [DRV_LINES-1:0] l;
    logic [KEY_BITS-1:0]  m;
    l = span_lines(s);
    for (int i = 0; i < KEY_BITS; i++) m[i] = l[i / SNS_LINES];
    return m;
  endfunction
endpackage

// File: rtl/key_scan_seq.sv
module key_scan_seq
  import key_scan_pkg::*;
#(
  parameter int SLOT_TICKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  span_e                span_i,
  output span_e                span_q_o,
  output logic [LINE_W-1:0]    line_o,
  output logic [DRV_LINES-1:0] drive_o,
  output logic [DRV_LINES-1:0] pin_scan_o,
  output logic                 sample_o,
  output logic                 frame_end_o,
  output logic                 restart_o
);
  localparam int CNT_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(SLOT_TICKS - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(DRV_LINES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [LINE_W-1:0] line_q;
  span_e             span_q;
  logic              slot_end;

  assign restart_o   = (span_i != span_q);
  assign slot_end    = tick_i && (cnt_q == CNT_LAST);
  assign sample_o    = slot_end && !restart_o;
  assign frame_end_o = sample_o && (line_q == LINE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      span_q <= SPAN_FULL;
      line_q <= '0;
      cnt_q  <= '0;
    end else if (restart_o) begin
      span_q <= span_i;
      line_q <= span_first(span_i);
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q  <= '0;
        line_q <= (line_q == LINE_LAST) ? span_first(span_q) : line_q + LINE_W'(1);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign pin_scan_o = span_lines(span_q);
  assign span_q_o   = span_q;
  assign line_o     = line_q;

  for (genvar g = 0; g < DRV_LINES; g++) begin : g_drv
    assign drive_o[g] = pin_scan_o[g] && (line_q == LINE_W'(g));
  end

  AST_ONE_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drive_o) && ((drive_o & ~pin_scan_o) == '0)); // R3
  AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && line_q != LINE_LAST) |=> (line_q == $past(line_q) + LINE_W'(1))); // R4
  AST_LINE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> (line_q == span_first(span_q))); // R4
  AST_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_o) |=> ($stable(line_q) && $stable(cnt_q))); // R5
  AST_RESTART_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> (line_q == span_first(span_q) && cnt_q == '0)); // R11
endmodule

// File: rtl/key_scan_capture.sv
module key_scan_capture
  import key_scan_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_i,
  input  logic                 frame_end_i,
  input  logic                 restart_i,
  input  logic [LINE_W-1:0]    line_i,
  input  logic [SNS_LINES-1:0] sense_i,
  input  span_e                span_i,
  output logic [KEY_BITS-1:0]  key_map_o,
  output logic                 ready_o
);
  logic [KEY_BITS-1:0] acc_q, prev_q, frame_w, masked_w, keep_w;
  logic                prev_ok_q;

  for (genvar g = 0; g < DRV_LINES; g++) begin : g_row
    assign frame_w[g*SNS_LINES +: SNS_LINES] =
      (sample_i && line_i == LINE_W'(g)) ? sense_i : acc_q[g*SNS_LINES +: SNS_LINES];
  end

  assign keep_w   = span_keys(span_i);
  assign masked_w = frame_w & keep_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
      key_map_o <= '0;
      ready_o   <= 1'b0;
    end else begin
      ready_o <= 1'b0;
      if (restart_i) begin
        acc_q     <= '0;
        prev_ok_q <= 1'b0;
      end else if (sample_i) begin
        acc_q <= frame_w;
        if (frame_end_i) begin
          prev_q    <= masked_w;
          prev_ok_q <= 1'b1;
          if (prev_ok_q && masked_w == prev_q && masked_w != key_map_o) begin
            key_map_o <= masked_w;
            ready_o   <= 1'b1;
          end
        end
      end
    end
  end

  AST_MAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(key_map_o)); // R9
  AST_READY_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (key_map_o != $past(key_map_o))); // R10
  AST_CHANGE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_map_o != $past(key_map_o)) |-> ready_o); // R10
  AST_RELEASED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ((key_map_o & ~keep_w) == '0)); // R8
  AST_RESTART_NOACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !ready_o); // R11
endmodule

// File: rtl/key_matrix_scan.sv
module key_matrix_scan
  import key_scan_pkg::*;
#(
  parameter int SLOT_TICKS = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic [1:0]  key_sel_i,
  input  logic [4:0]  sense_i,
  output logic [5:0]  drive_o,
  output logic [5:0]  pin_scan_o,
  output logic [29:0] key_map_o,
  output logic        ready_o
);
  span_e             span_req, span_cur;
  logic [LINE_W-1:0] line;
  logic              sample, frame_end, restart;

  assign span_req = span_decode(key_sel_i);

  key_scan_seq #(.SLOT_TICKS(SLOT_TICKS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .span_i      (span_req),
    .span_q_o    (span_cur),
    .line_o      (line),
    .drive_o     (drive_o),
    .pin_scan_o  (pin_scan_o),
    .sample_o    (sample),
    .frame_end_o (frame_end),
    .restart_o   (restart)
  );

  key_scan_capture u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_i    (sample),
    .frame_end_i (frame_end),
    .restart_i   (restart),
    .line_i      (line),
    .sense_i     (sense_i),
    .span_i      (span_cur),
    .key_map_o   (key_map_o),
    .ready_o     (ready_o)
  );
endmodule

// File: tb/key_matrix_scan_test.sv
module key_matrix_scan_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 4;
  localparam int SETTLE = 4 * 6 * SLOT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [29:0] pressed = '0;
  logic [4:0]  sense;
  logic [5:0]  drive, pin_scan, last_drive = '0;
  logic [29:0] key_map, exp_map;
  logic        ready;
  int          age = 7;
  int          ready_cnt = 0;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  key_matrix_scan #(.SLOT_TICKS(SLOT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .key_sel_i(mode), .sense_i(sense),
    .drive_o(drive), .pin_scan_o(pin_scan), .key_map_o(key_map), .ready_o(ready)
  );

  // matrix model: sense is garbage until the drive line is two cycles old
  always_comb begin
    logic [4:0] s;
    s = '0;
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 5; c++)
        if (drive[r] && pressed[r*5+c]) s[c] = 1'b1;
    sense = (age >= 2) ? s : 5'h1F;
  end

  always @(negedge clk) begin
    if (drive != last_drive) age <= 0;
    else if (age < 7) age <= age + 1;
    last_drive <= drive;
    if (rst_n && ready) ready_cnt <= ready_cnt + 1;
  end

  function automatic int first_of(logic [1:0] m);
    return m[1] ? 2 : (m[0] ? 1 : 0);
  endfunction

  function automatic logic [29:0] keep_of(logic [1:0] m);
    return ~30'd0 << (first_of(m) * 5);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply(logic [1:0] m, logic [29:0] p, string req);
    logic [29:0] want;
    int          want_rdy;
    want = p & keep_of(m);
    want_rdy = (want != exp_map) ? 1 : 0;
    ready_cnt = 0;
    mode = m;
    pressed = p;
    cycles(SETTLE);
    check(key_map == want, req, 32'(key_map), 32'(want));
    check(ready_cnt == want_rdy, "R10 ready count", 32'(ready_cnt), 32'(want_rdy));
    exp_map = want;
  endtask

  task automatic order_run(logic [1:0] m);
    int errs, nl, f;
    errs = 0;
    mode = (m == 2'b00) ? 2'b01 : 2'b00;
    cycles(3);
    mode = m;
    cycles(1);
    f = first_of(m);
    nl = 6 - f;
    for (int k = 0; k < 2 * nl * SLOT; k++) begin
      if (drive != 6'(1 << (f + (k / SLOT) % nl))) errs++;
      if ($countones(drive) != 1) errs++;
      cycles(1);
    end
    check(errs == 0, "R4 R3 drive order", 32'(errs), 32'd0);
  endtask

  initial begin
    int errs;
    logic [5:0] held;
    exp_map = '0;
    cycles(3);
    rst_n = 1'b1;
    tick = 1'b1;
    check(key_map == '0, "R1 map", 32'(key_map), 0);
    check(ready == 1'b0, "R1 ready", 32'(ready), 0);

    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      cycles(2);
      check(pin_scan == 6'(~6'd0 << first_of(2'(m))), "R2 pin use", 32'(pin_scan),
            32'(6'(~6'd0 << first_of(2'(m)))));
    end
    mode = 2'b00;
    cycles(SETTLE);

    for (int m = 0; m < 3; m++) order_run(2'(m));
    mode = 2'b00;
    cycles(SETTLE);

    // R5: tick paused
    tick = 1'b0;
    cycles(1);
    held = drive;
    errs = 0;
    for (int k = 0; k < 12; k++) begin
      cycles(1);
      if (drive != held) errs++;
    end
    check(errs == 0, "R5 hold without tick", 32'(errs), 0);
    tick = 1'b1;

    // R7 R8 R10: single-key sweep in every select value
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 30; k++)
        apply(2'(m), 30'(1) << k, "R7 R8 single key");

    apply(2'b00, '0, "R6 garbage in early slot ignored");
    apply(2'b00, ~30'd0, "R7 all keys");
    apply(2'b01, ~30'd0, "R8 25-key mask");
    apply(2'b10, ~30'd0, "R8 20-key mask");
    apply(2'b11, 30'h0000_03FF, "R8 released lines only");
    apply(2'b00, 30'h2AAA_AAAA, "R7 alternating A");
    apply(2'b00, 30'h1555_5555, "R7 alternating B");
    apply(2'b00, 30'h1555_5555, "R10 repeat same");
    apply(2'b00, '0, "R7 clear");

    // R9: key seen on one pass only
    ready_cnt = 0;
    pressed = 30'(1) << 17;
    cycles(6 * SLOT);
    pressed = '0;
    cycles(SETTLE);
    check(key_map == '0, "R9 single pass rejected", 32'(key_map), 0);
    check(ready_cnt == 0, "R9 no ready", 32'(ready_cnt), 0);

    // R11: select change mid-pass restarts scan
    apply(2'b00, ~30'd0, "R7 all keys again");
    cycles(SLOT + 1);
    mode = 2'b10;
    cycles(1);
    check(drive == 6'b000100, "R11 restart line", 32'(drive), 32'h4);
    cycles(4 * SLOT + 2);
    check(key_map == ~30'd0, "R11 first pass discarded", 32'(key_map), 32'h3FFF_FFFF);
    cycles(4 * SLOT + 4);
    check(key_map == keep_of(2'b10), "R11 map after restart", 32'(key_map),
          32'(keep_of(2'b10)));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule